// File: doc/BRIEF.md
# Hint-Driven Thread Fetch Scheduler

This block picks, every cycle, which hardware thread of a multithreaded in-order shader core supplies the next instruction fetch, and which program counter that fetch uses. Each instruction word returned from instruction memory carries one extra bit beyond its ordinary encoding. A compiler pass sets this bit ahead of time when the following instruction of the same thread would wait on a long-latency result. The scheduler samples that bit in the same cycle as the fetch. When the bit is set, the next fetch already comes from another ready thread, so a thread switch costs no pipeline bubble. The scheduler never waits for a stall to show up at decode.

Scheduling is blocked and non-preemptive. The running thread keeps issuing until its hint fires. That thread is then parked as blocked. It becomes eligible again when the long-latency unit returns a wake-up strobe tagged with its thread ID. The replacement thread is found round-robin, starting at the thread after the current one. When every thread is blocked, fetch stops until a wake-up arrives, and the current thread ID is held. A taken branch reported during a fetch overrides the sequential increment of that thread's PC.

Top module: `hint_thread_sched`

## Requirements
- R1: After synchronous reset, every thread is ready. The current thread is 0, `fetch_valid` is 1, and thread i starts at PC `PC_BASE + i*PC_STRIDE`. Defaults: base 0, stride 0x1000.
- R2: In a valid fetch cycle with `instr_hint`=0 and no taken branch, the next cycle fetches the same thread at PC + `PC_STEP` (default 4). A wake-up for another thread does not change this.
- R3: In a valid fetch cycle with `instr_hint`=1, the very next cycle fetches from a different ready thread if one exists. No idle cycle is inserted.
- R4: The replacement thread is the first ready thread in the order cur+1, cur+2, … modulo 4, where thread IDs are 2-bit values 0..3.
- R5: A thread whose hint fired is blocked and is never chosen again until it is woken.
- R6: A cycle with `wake_valid`=1 makes thread `wake_tid` ready. If fetch was idle, the next cycle fetches that thread with `fetch_valid`=1.
- R7: If no thread is ready, `fetch_valid` is 0 and `fetch_tid` keeps its previous value until a wake-up arrives.
- R8: If a hint blocks a thread in the same cycle that a wake-up targets it, the thread ends up ready. When no other thread is ready, it is fetched again on the next cycle.
- R9: In a valid fetch cycle with `br_taken`=1, that thread's next PC is `br_target` instead of PC + `PC_STEP`.
- R10: A blocked thread resumes at the PC that follows its hinted instruction (or at the branch target).
- R11: `instr_hint`, `br_taken` and `br_target` are ignored while `fetch_valid` is 0. They change neither the thread states nor any PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_hint | input | 1 | Hint bit of the instruction fetched this cycle |
| br_taken | input | 1 | Taken branch for the thread fetched this cycle |
| br_target | input | PC_W | Branch target PC |
| wake_valid | input | 1 | Wake-up strobe from a long-latency unit |
| wake_tid | input | 2 | Thread ID being woken |
| fetch_valid | output | 1 | A fetch is issued this cycle |
| fetch_tid | output | 2 | Thread ID of the fetch |
| fetch_pc | output | PC_W | PC of the fetch |

## Verification
The assertions assume that `instr_hint` and `br_taken` refer to the instruction fetched in the same cycle. They also assume at most one wake-up per cycle, and that the wake-up targets a thread that is blocked or is being blocked in that cycle. The directed stimulus follows these rules. It raises the hint and branch only against the fetch that is currently presented, and it sends each wake-up only to a thread it has previously parked. The one deliberate exception is the idle-cycle stimulus used for R11. That stimulus drives hint and branch inputs while no fetch is valid, to show that they are discarded.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NTHR  = 4;
    localparam int TID_W = $clog2(NTHR);

    typedef logic [TID_W-1:0] tid_t;
    typedef logic [NTHR-1:0]  tmask_t;

    // A per-thread event: strobe plus target thread
    typedef struct packed {
        logic fire;
        tid_t tid;
    } tevt_t;

    // Result of a round-robin search
    typedef struct packed {
        logic found;
        tid_t tid;
    } pick_t;

    // First set bit of m at offsets cur+1 .. cur+NTHR (wrapping)
    function automatic pick_t rr_pick(tmask_t m, tid_t cur);
        pick_t p;
        p.found = 1'b0;
        p.tid   = cur;
        for (int off = NTHR; off >= 1; off--) begin
            int idx;
            idx = (int'(cur) + off) % NTHR;
            if (m[idx]) begin
                p.found = 1'b1;
                p.tid   = tid_t'(idx);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sched_ready_bank.sv
module sched_ready_bank
    import sched_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tevt_t  blk,
    input  tevt_t  wake,
    output tmask_t ready_q,
    output tmask_t ready_nx
);

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        logic hit_blk;
        logic hit_wake;

        assign hit_blk  = blk.fire  && (blk.tid  == tid_t'(i));
        assign hit_wake = wake.fire && (wake.tid == tid_t'(i));
        // wake-up wins over a same-cycle block
        assign ready_nx[i] = (ready_q[i] && !hit_blk) || hit_wake;

        always_ff @(posedge clk) begin
            if (rst) ready_q[i] <= 1'b1;
            else     ready_q[i] <= ready_nx[i];
        end
    end

endmodule

// File: rtl/sched_pc_bank.sv
module sched_pc_bank
    import sched_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] PC_BASE   = '0,
    parameter logic [PC_W-1:0] PC_STRIDE = PC_W'(32'h1000),
    parameter logic [PC_W-1:0] PC_STEP   = PC_W'(4)
) (
    input  logic            clk,
    input  logic            rst,
    input  tevt_t           upd,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    input  tid_t            rd_tid,
    output logic [PC_W-1:0] rd_pc
);

    logic [PC_W-1:0] pc_q [NTHR];

    for (genvar i = 0; i < NTHR; i++) begin : g_pc
        localparam logic [PC_W-1:0] START = PC_BASE + PC_W'(i) * PC_STRIDE;

        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q[i] <= START;
            end else if (upd.fire && upd.tid == tid_t'(i)) begin
                pc_q[i] <= br_taken ? br_target : pc_q[i] + PC_STEP;
            end
        end
    end

    assign rd_pc = pc_q[rd_tid];

endmodule

// File: rtl/sched_rr_select.sv
module sched_rr_select
    import sched_pkg::*;
(
    input  tid_t   cur_tid,
    input  logic   cur_issue,
    input  logic   cur_hint,
    input  tmask_t ready_nx,
    output tid_t   next_tid
);

    pick_t pick;
    logic  stay;

    assign stay = cur_issue && !cur_hint;
    assign pick = rr_pick(ready_nx, cur_tid);

    always_comb begin
        if (stay)            next_tid = cur_tid;
        else if (pick.found) next_tid = pick.tid;
        else                 next_tid = cur_tid;
    end

endmodule

// File: rtl/hint_thread_sched.sv
module hint_thread_sched
    import sched_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] PC_BASE   = '0,
    parameter logic [PC_W-1:0] PC_STRIDE = PC_W'(32'h1000),
    parameter logic [PC_W-1:0] PC_STEP   = PC_W'(4)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_hint,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    input  logic            wake_valid,
    input  logic [TID_W-1:0] wake_tid,
    output logic            fetch_valid,
    output logic [TID_W-1:0] fetch_tid,
    output logic [PC_W-1:0] fetch_pc
);

    tid_t   cur_q;
    tid_t   cur_nx;
    tmask_t ready_q;
    tmask_t ready_nx;
    tevt_t  blk_ev;
    tevt_t  wake_ev;
    tevt_t  pc_ev;

    assign fetch_valid = ready_q[cur_q];
    assign fetch_tid   = cur_q;

    assign blk_ev  = '{fire: fetch_valid && instr_hint, tid: cur_q};
    assign wake_ev = '{fire: wake_valid, tid: wake_tid};
    assign pc_ev   = '{fire: fetch_valid, tid: cur_q};

    sched_ready_bank u_ready (
        .clk      (clk),
        .rst      (rst),
        .blk      (blk_ev),
        .wake     (wake_ev),
        .ready_q  (ready_q),
        .ready_nx (ready_nx)
    );

    sched_pc_bank #(
        .PC_W      (PC_W),
        .PC_BASE   (PC_BASE),
        .PC_STRIDE (PC_STRIDE),
        .PC_STEP   (PC_STEP)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .upd       (pc_ev),
        .br_taken  (br_taken),
        .br_target (br_target),
        .rd_tid    (cur_q),
        .rd_pc     (fetch_pc)
    );

    sched_rr_select u_sel (
        .cur_tid   (cur_q),
        .cur_issue (fetch_valid),
        .cur_hint  (instr_hint),
        .ready_nx  (ready_nx),
        .next_tid  (cur_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= cur_nx;
    end

endmodule

// File: rtl/sched_checker.sv
module sched_checker
    import sched_pkg::*;
#(
    parameter int              PC_W    = 32,
    parameter logic [PC_W-1:0] PC_STEP = PC_W'(4)
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_hint,
    input logic            br_taken,
    input logic [PC_W-1:0] br_target,
    input logic            wake_valid,
    input tid_t            wake_tid,
    input logic            fetch_valid,
    input tid_t            fetch_tid,
    input logic [PC_W-1:0] fetch_pc
);

    // R2
    seq_stay_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && !instr_hint && !br_taken
        |=> fetch_valid && fetch_tid == $past(fetch_tid)
            && fetch_pc == $past(fetch_pc) + PC_STEP);

    // R3
    hint_switch_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && instr_hint && !(wake_valid && wake_tid == fetch_tid)
        |=> !fetch_valid || fetch_tid != $past(fetch_tid));

    // R9
    branch_target_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && br_taken && !instr_hint
        |=> fetch_pc == $past(br_target));

    // R6
    wake_resume_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid && wake_valid
        |=> fetch_valid && fetch_tid == $past(wake_tid));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid && !wake_valid
        |=> !fetch_valid && $stable(fetch_tid));

    // R8
    wake_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && instr_hint && wake_valid && wake_tid == fetch_tid
        |=> fetch_valid);

endmodule

bind hint_thread_sched sched_checker #(
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_hint  (instr_hint),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .wake_valid  (wake_valid),
    .wake_tid    (wake_tid),
    .fetch_valid (fetch_valid),
    .fetch_tid   (fetch_tid),
    .fetch_pc    (fetch_pc)
);

// File: tb/sim_hint_thread_sched.sv
`timescale 1ns/1ps
module sim_hint_thread_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_hint = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        wake_valid = 1'b0;
    logic [1:0]  wake_tid = '0;
    logic        fetch_valid;
    logic [1:0]  fetch_tid;
    logic [31:0] fetch_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hint_thread_sched u0 (
        .clk         (clk),
        .rst         (rst),
        .instr_hint  (instr_hint),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .wake_valid  (wake_valid),
        .wake_tid    (wake_tid),
        .fetch_valid (fetch_valid),
        .fetch_tid   (fetch_tid),
        .fetch_pc    (fetch_pc)
    );

    task automatic expect_fetch(string req, logic ev, logic [1:0] et, logic [31:0] ep, bit pc_used);
        checks++;
        if (fetch_valid !== ev || fetch_tid !== et || (pc_used && fetch_pc !== ep)) begin
            failures++;
            $display("FAIL %s: got valid=%0b tid=%0d pc=%h, expected valid=%0b tid=%0d pc=%h",
                     req, fetch_valid, fetch_tid, fetch_pc, ev, et, ep);
        end
    endtask

    task automatic tick(logic h, logic bt, logic [31:0] tgt, logic wv, logic [1:0] wt);
        instr_hint = h; br_taken = bt; br_target = tgt; wake_valid = wv; wake_tid = wt;
        @(posedge clk);
        #1;
        instr_hint = 0; br_taken = 0; br_target = '0; wake_valid = 0; wake_tid = '0;
    endtask

    task automatic t_reset;
        expect_fetch("R1 reset", 1, 0, 32'h0, 1);
    endtask

    task automatic t_sequential;
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0);
        expect_fetch("R2 sequential", 1, 0, 32'h8, 1);
    endtask

    task automatic t_switch_and_branch;
        tick(1, 0, 0, 0, 0);
        expect_fetch("R3 R4 zero-penalty switch", 1, 1, 32'h1000, 1);
        tick(0, 1, 32'h1800, 0, 0);
        expect_fetch("R9 taken branch", 1, 1, 32'h1800, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R3 switch to thread 2", 1, 2, 32'h2000, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R3 switch to thread 3", 1, 3, 32'h3000, 1);
    endtask

    task automatic t_all_blocked;
        tick(1, 0, 0, 0, 0);
        expect_fetch("R7 R5 all blocked", 0, 3, 32'h0, 0);
        tick(1, 1, 32'hDEAD0, 0, 0);
        expect_fetch("R11 idle inputs ignored", 0, 3, 32'h0, 0);
        tick(0, 0, 0, 0, 0);
        expect_fetch("R7 tid held", 0, 3, 32'h0, 0);
    endtask

    task automatic t_wake;
        tick(0, 0, 0, 1, 1);
        expect_fetch("R6 R10 wake from idle", 1, 1, 32'h1804, 1);
        tick(0, 0, 0, 1, 0);
        expect_fetch("R2 foreign wake no effect", 1, 1, 32'h1808, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R4 R10 wrap to thread 0", 1, 0, 32'hC, 1);
    endtask

    task automatic t_same_cycle;
        tick(1, 0, 0, 1, 0);
        expect_fetch("R8 wake beats block", 1, 0, 32'h10, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R7 idle again", 0, 0, 32'h0, 0);
        tick(0, 1, 32'h5550, 0, 0);
        tick(0, 0, 0, 1, 0);
        expect_fetch("R11 idle branch discarded", 1, 0, 32'h14, 1);
    endtask

    task automatic t_rr_order;
        tick(0, 0, 0, 1, 2);
        tick(0, 0, 0, 1, 3);
        expect_fetch("R2 run during wakes", 1, 0, 32'h1C, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R4 skip blocked thread 1", 1, 2, 32'h2004, 1);
        tick(0, 0, 0, 1, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R4 thread 3 before 1", 1, 3, 32'h3004, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R4 R10 thread 1 resumes", 1, 1, 32'h180C, 1);
        tick(1, 0, 0, 0, 0);
        expect_fetch("R5 blocked threads skipped", 0, 1, 32'h0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_sequential();
        t_switch_and_branch();
        t_all_blocked();
        t_wake();
        t_same_cycle();
        t_rr_order();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule